// File: doc/BRIEF.md
# SPI Master Serial Shift Engine

This block is the serial core of an SPI master. Words waiting to go out sit in a transmit FIFO, and words coming back are collected in a receive FIFO. The engine takes one word at a time from the transmit FIFO. It shifts that word out on `mosi` while it samples `miso`. When the word is complete, the received bits go into the receive FIFO as one word. The engine keeps pulling words for as long as the transmit FIFO has data and the receive FIFO has room.

Several settings come in on plain configuration inputs and are held steady while the engine is busy: the clock prescale, the word length, the clock polarity and phase, and the gap between words. Chip selects are driven from a select mask and an enable. A busy flag covers the shifting of each word. A one-cycle completion pulse follows the last word of a burst. A synchronous clear empties both FIFOs and stops the engine, and it leaves the chip selects as they are.

Top module: `spi_shift_engine`

## Requirements
- R1: While a word is shifting, each SCK half-period lasts `cfgDiv+1` clock cycles, so the SCK period is `2*(cfgDiv+1)` cycles.
- R2: A word is `cfgWordLen+1` bits long (field value 31 gives 32 bits). It takes the low `cfgWordLen+1` bits of the pushed transmit word and sends them most significant bit first, one bit per SCK period.
- R3: Whenever `busy` is low, `sck` equals `cfgCpol`.
- R4: With `cfgCpha`=0, `mosi` changes only on trailing SCK edges (the first bit is present before the first leading edge) and `miso` is sampled on leading edges. With `cfgCpha`=1, `mosi` changes only on leading edges and `miso` is sampled on trailing edges. Received bits are right-aligned in the receive word, first bit most significant, and the unused upper bits are zero.
- R5: Between two consecutive words of a burst, `busy` stays low for exactly `cfgInterval*4+10` clock cycles.
- R6: Chip selects are registered. One cycle after a change, `csN` equals `~cfgCsSel` when `csEnable` is 1 and all ones otherwise. `fifoClear` does not change `csN`.
- R7: The transmit FIFO holds 32 words and raises `txFull` when it holds 32 words. A push while `txFull` is high is dropped.
- R8: `busy` rises when a word is loaded. It falls in the cycle after the final trailing SCK edge of that word. If the transmit FIFO is empty at that point, `done` pulses for one cycle, and `busy` is low during that cycle.
- R9: `fifoClear` empties both FIFOs and returns the engine to idle in the next cycle, with `busy` low and SCK at its idle level. It produces no `done` pulse.
- R10: The engine does not start a word while the receive FIFO (32 words) is full, so no received word is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifoClear | input | 1 | Synchronous clear of both FIFOs and the engine |
| cfgDiv | input | 8 | SCK prescale value |
| cfgWordLen | input | 5 | Word length minus one |
| cfgInterval | input | 6 | Inter-word gap setting |
| cfgCpol | input | 1 | SCK idle level |
| cfgCpha | input | 1 | Clock phase select |
| cfgCsSel | input | 4 | Chip-select mask, 1 = select that line |
| csEnable | input | 1 | Assert the selected chip selects |
| txPush | input | 1 | Write `txData` into the transmit FIFO |
| txData | input | 32 | Transmit word |
| txFull | output | 1 | Transmit FIFO holds 32 words |
| txEmpty | output | 1 | Transmit FIFO is empty |
| rxPop | input | 1 | Remove the head word of the receive FIFO |
| rxData | output | 32 | Head word of the receive FIFO (show-ahead) |
| rxEmpty | output | 1 | Receive FIFO is empty |
| rxFull | output | 1 | Receive FIFO holds 32 words |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csN | output | 4 | Active-low chip selects |
| busy | output | 1 | A word is being shifted |
| done | output | 1 | One-cycle pulse at the end of a burst |

## Verification
The hardest state to reach is one where the engine has transmit words ready but must hold back because the receive FIFO is full. While it is stalled, the transmit FIFO can be driven to full and pushed once more. The bench gets there by running 32 one-bit words with nothing popped, so the receive side saturates. It then checks that the engine stays idle, fills the transmit FIFO, and makes one extra push. Finally it drains the receive FIFO in order, and the count of words that come back shows whether the extra push was dropped. The inter-word gap and the edge placement are measured by a monitor that sweeps polarity, phase, prescale and word length together.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_GAP,
    ST_DONE
  } engState_t;

  // Strobes from the control to the datapath, valid for one cycle each.
  typedef struct packed {
    logic load;      // take a new transmit word
    logic lead;      // leading SCK edge at the end of this cycle
    logic trail;     // trailing SCK edge at the end of this cycle
    logic lastBit;   // current bit is the final bit of the word
    logic flush;     // synchronous clear
  } engStrobe_t;

endpackage

// File: rtl/spi_eng_fifo.sv
module spi_eng_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] popData,
  output logic             full,
  output logic             empty
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0]      wrPtr, rdPtr;
  logic             doPush, doPop;
  logic [AW:0]      fillLevel;

  assign empty     = (wrPtr == rdPtr);
  assign full      = (wrPtr[AW] != rdPtr[AW]) && (wrPtr[AW-1:0] == rdPtr[AW-1:0]);
  assign doPush    = push && !full;
  assign doPop     = pop && !empty;
  assign popData   = mem[rdPtr[AW-1:0]];
  assign fillLevel = wrPtr - rdPtr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (doPush && !clear) mem[wrPtr[AW-1:0]] <= pushData;
  end

  assert_fill_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fillLevel <= (AW+1)'(DEPTH));

  assert_push_full_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !clear) |=> (full && $stable(fillLevel)));

endmodule

// File: rtl/spi_eng_ctrl.sv
module spi_eng_ctrl
  import spi_eng_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int LEN_W = 5,
  parameter int GAP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [DIV_W-1:0] cfgDiv,
  input  logic [LEN_W-1:0] cfgWordLen,
  input  logic [GAP_W-1:0] cfgInterval,
  input  logic             txEmpty,
  input  logic             rxFull,
  output engStrobe_t       strobe,
  output logic             txPop,
  output logic             rxPush,
  output logic             busy,
  output logic             done
);
  localparam int GCNT_W = GAP_W + 3;

  engState_t        state;
  logic [DIV_W-1:0] halfCnt;
  logic             secondHalf;
  logic [LEN_W-1:0] bitCnt;
  logic [GCNT_W-1:0] gapCnt, gapLen;
  logic             startOk, gapEnd, edgeNow, lastBit, loadNow;

  assign gapLen  = GCNT_W'({cfgInterval, 2'b00}) + GCNT_W'(10);
  assign gapEnd  = (gapCnt == gapLen - 1'b1);
  assign startOk = !txEmpty && !rxFull;
  assign edgeNow = (state == ST_SHIFT) && (halfCnt == cfgDiv);
  assign lastBit = (bitCnt == cfgWordLen);
  assign loadNow = startOk && ((state == ST_IDLE) || (state == ST_GAP && gapEnd));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      halfCnt    <= '0;
      secondHalf <= 1'b0;
      bitCnt     <= '0;
      gapCnt     <= '0;
    end else if (flush) begin
      state      <= ST_IDLE;
      halfCnt    <= '0;
      secondHalf <= 1'b0;
      bitCnt     <= '0;
      gapCnt     <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (startOk) begin
            state      <= ST_SHIFT;
            halfCnt    <= '0;
            secondHalf <= 1'b0;
            bitCnt     <= '0;
          end
        end
        ST_SHIFT: begin
          if (edgeNow) begin
            halfCnt    <= '0;
            secondHalf <= !secondHalf;
            if (secondHalf) begin
              if (lastBit) begin
                state  <= txEmpty ? ST_DONE : ST_GAP;
                gapCnt <= '0;
              end else begin
                bitCnt <= bitCnt + 1'b1;
              end
            end
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end
        ST_GAP: begin
          if (gapEnd) begin
            state      <= startOk ? ST_SHIFT : ST_IDLE;
            halfCnt    <= '0;
            secondHalf <= 1'b0;
            bitCnt     <= '0;
          end else begin
            gapCnt <= gapCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.load    = loadNow && !flush;
    strobe.lead    = edgeNow && !secondHalf && !flush;
    strobe.trail   = edgeNow && secondHalf && !flush;
    strobe.lastBit = lastBit;
    strobe.flush   = flush;
  end

  assign txPop  = strobe.load;
  assign rxPush = strobe.trail && lastBit;
  assign busy   = (state == ST_SHIFT);
  assign done   = (state == ST_DONE);

  assert_done_follows_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));

  assert_busy_drops_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rxPush && !flush) |=> !busy);

  assert_no_rx_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rxPush |-> !rxFull);

  assert_start_has_room_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!rxFull));

endmodule

// File: rtl/spi_eng_dp.sv
module spi_eng_dp
  import spi_eng_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  engStrobe_t        strobe,
  input  logic              cfgCpha,
  input  logic [LEN_W-1:0]  cfgWordLen,
  input  logic [DATA_W-1:0] txWord,
  input  logic              miso,
  output logic              sckPhase,
  output logic              mosi,
  output logic [DATA_W-1:0] rxWord
);
  logic [DATA_W-1:0] shiftReg, rxShift, loadWord;
  logic [LEN_W-1:0]  alignShift;

  assign alignShift = LEN_W'(DATA_W - 1) - cfgWordLen;
  assign loadWord   = txWord << alignShift;
  // Final received word, including the bit sampled on a last trailing edge.
  assign rxWord     = cfgCpha ? {rxShift[DATA_W-2:0], miso} : rxShift;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftReg <= '0;
      rxShift  <= '0;
      mosi     <= 1'b0;
      sckPhase <= 1'b0;
    end else if (strobe.flush) begin
      rxShift  <= '0;
      sckPhase <= 1'b0;
    end else if (strobe.load) begin
      rxShift  <= '0;
      sckPhase <= 1'b0;
      if (!cfgCpha) begin
        mosi     <= loadWord[DATA_W-1];
        shiftReg <= loadWord << 1;
      end else begin
        shiftReg <= loadWord;
      end
    end else if (strobe.lead) begin
      sckPhase <= 1'b1;
      if (cfgCpha) begin
        mosi     <= shiftReg[DATA_W-1];
        shiftReg <= shiftReg << 1;
      end else begin
        rxShift <= {rxShift[DATA_W-2:0], miso};
      end
    end else if (strobe.trail) begin
      sckPhase <= 1'b0;
      if (cfgCpha) begin
        rxShift <= {rxShift[DATA_W-2:0], miso};
      end else if (!strobe.lastBit) begin
        mosi     <= shiftReg[DATA_W-1];
        shiftReg <= shiftReg << 1;
      end
    end
  end

  assert_mosi_hold_lead_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.lead && !cfgCpha) |=> $stable(mosi));

  assert_mosi_hold_trail_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.trail && cfgCpha) |=> $stable(mosi));

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_eng_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int DIV_W    = 8,
  parameter int GAP_W    = 6,
  parameter int CS_N     = 4,
  parameter int TX_DEPTH = 32,
  parameter int RX_DEPTH = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      fifoClear,
  input  logic [DIV_W-1:0]          cfgDiv,
  input  logic [$clog2(DATA_W)-1:0] cfgWordLen,
  input  logic [GAP_W-1:0]          cfgInterval,
  input  logic                      cfgCpol,
  input  logic                      cfgCpha,
  input  logic [CS_N-1:0]           cfgCsSel,
  input  logic                      csEnable,
  input  logic                      txPush,
  input  logic [DATA_W-1:0]         txData,
  output logic                      txFull,
  output logic                      txEmpty,
  input  logic                      rxPop,
  output logic [DATA_W-1:0]         rxData,
  output logic                      rxEmpty,
  output logic                      rxFull,
  output logic                      sck,
  output logic                      mosi,
  input  logic                      miso,
  output logic [CS_N-1:0]           csN,
  output logic                      busy,
  output logic                      done
);
  localparam int LEN_W = $clog2(DATA_W);

  engStrobe_t        strobe;
  logic              txPop, rxPush, sckPhase;
  logic [DATA_W-1:0] txHead, rxWord;

  spi_eng_fifo #(.WIDTH(DATA_W), .DEPTH(TX_DEPTH)) u_txFifo (
    .clk(clk), .rst_n(rst_n), .clear(fifoClear),
    .push(txPush), .pushData(txData),
    .pop(txPop), .popData(txHead),
    .full(txFull), .empty(txEmpty)
  );

  spi_eng_fifo #(.WIDTH(DATA_W), .DEPTH(RX_DEPTH)) u_rxFifo (
    .clk(clk), .rst_n(rst_n), .clear(fifoClear),
    .push(rxPush), .pushData(rxWord),
    .pop(rxPop), .popData(rxData),
    .full(rxFull), .empty(rxEmpty)
  );

  spi_eng_ctrl #(.DIV_W(DIV_W), .LEN_W(LEN_W), .GAP_W(GAP_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .flush(fifoClear),
    .cfgDiv(cfgDiv), .cfgWordLen(cfgWordLen), .cfgInterval(cfgInterval),
    .txEmpty(txEmpty), .rxFull(rxFull),
    .strobe(strobe), .txPop(txPop), .rxPush(rxPush),
    .busy(busy), .done(done)
  );

  spi_eng_dp #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .cfgCpha(cfgCpha), .cfgWordLen(cfgWordLen),
    .txWord(txHead), .miso(miso),
    .sckPhase(sckPhase), .mosi(mosi), .rxWord(rxWord)
  );

  assign sck = sckPhase ^ cfgCpol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) csN <= '1;
    else        csN <= csEnable ? ~cfgCsSel : '1;
  end

  assert_sck_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sck == cfgCpol));

  assert_clear_keeps_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fifoClear |=> (!busy && !done && txEmpty && rxEmpty));

endmodule

// File: tb/spi_shift_engine_test.sv
module spi_shift_engine_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifoClear = 1'b0;
  logic [7:0] cfgDiv = '0;
  logic [4:0] cfgWordLen = '0;
  logic [5:0] cfgInterval = '0;
  logic cfgCpol = 1'b0, cfgCpha = 1'b0;
  logic [3:0] cfgCsSel = '0;
  logic csEnable = 1'b0;
  logic txPush = 1'b0;
  logic [31:0] txData = '0;
  logic txFull, txEmpty, rxPop, rxEmpty, rxFull, sck, mosi, miso, busy, done;
  logic [31:0] rxData;
  logic [3:0] csN;
  logic invMiso = 1'b0;

  int passCnt = 0, totalCnt = 0;
  bit finished = 1'b0;

  initial rxPop = 1'b0;
  always #2 clk = ~clk;
  assign miso = mosi ^ invMiso;

  spi_shift_engine uut (
    .clk(clk), .rst_n(rst_n), .fifoClear(fifoClear),
    .cfgDiv(cfgDiv), .cfgWordLen(cfgWordLen), .cfgInterval(cfgInterval),
    .cfgCpol(cfgCpol), .cfgCpha(cfgCpha), .cfgCsSel(cfgCsSel), .csEnable(csEnable),
    .txPush(txPush), .txData(txData), .txFull(txFull), .txEmpty(txEmpty),
    .rxPop(rxPop), .rxData(rxData), .rxEmpty(rxEmpty), .rxFull(rxFull),
    .sck(sck), .mosi(mosi), .miso(miso), .csN(csN), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    totalCnt++;
    if (ok) passCnt++;
    else $display("FAIL %s: actual %h expected %h", req, act, exp);
  endtask

  // Monitor state, reset whenever the main flow bumps monEpoch.
  int monEpoch = 0, seenEpoch = 0;
  int edgeCnt, lowCnt, wordsSeen, doneCnt, capBits, gapChecks;
  bit halfBad, phaseBad, gapBad, doneBusy;
  logic [31:0] capWord;
  logic [31:0] capArr [2];
  int bitsArr [2];
  logic prevSck, prevMosi, prevBusy;

  always @(negedge clk) begin
    if (seenEpoch != monEpoch) begin
      seenEpoch = monEpoch;
      edgeCnt = 0; lowCnt = 0; wordsSeen = 0; doneCnt = 0; capBits = 0; gapChecks = 0;
      halfBad = 0; phaseBad = 0; gapBad = 0; doneBusy = 0; capWord = '0;
      capArr[0] = '0; capArr[1] = '0; bitsArr[0] = 0; bitsArr[1] = 0;
    end
    edgeCnt++;
    if (busy && !prevBusy) begin
      edgeCnt = 0;
      capWord = '0;
      capBits = 0;
      if (wordsSeen > 0) begin
        gapChecks++;
        if (lowCnt != int'(cfgInterval) * 4 + 10) gapBad = 1;
      end
    end
    if (sck !== prevSck && rst_n) begin
      if (edgeCnt != int'(cfgDiv) + 1) halfBad = 1;
      edgeCnt = 0;
      if ((prevSck == cfgCpol) ^ cfgCpha) begin
        capWord = {capWord[30:0], mosi};
        capBits++;
      end
      if (mosi !== prevMosi && ((prevSck == cfgCpol) != cfgCpha)) phaseBad = 1;
    end
    if (!busy && prevBusy) begin
      if (wordsSeen < 2) begin
        capArr[wordsSeen] = capWord;
        bitsArr[wordsSeen] = capBits;
      end
      wordsSeen++;
      lowCnt = 1;
    end else if (!busy) begin
      lowCnt++;
    end
    if (done) begin
      doneCnt++;
      if (busy) doneBusy = 1;
    end
    prevSck = sck; prevMosi = mosi; prevBusy = busy;
  end

  task automatic pushTwo(input logic [31:0] a, input logic [31:0] b);
    @(negedge clk); txPush = 1'b1; txData = a;
    @(negedge clk); txData = b;
    @(negedge clk); txPush = 1'b0;
  endtask

  task automatic pushOne(input logic [31:0] a);
    @(negedge clk); txPush = 1'b1; txData = a;
    @(negedge clk); txPush = 1'b0;
  endtask

  task automatic popRx(output logic [31:0] w, output bit got);
    got = 1'b0;
    w = '0;
    for (int t = 0; t < 400 && !got; t++) begin
      @(negedge clk);
      if (!rxEmpty) got = 1'b1;
    end
    if (got) begin
      w = rxData;
      rxPop = 1'b1;
      @(negedge clk);
      rxPop = 1'b0;
    end
  endtask

  task automatic runConfig(input int pol, input int pha, input int div, input int len,
                           input int ivl, input bit inv);
    logic [31:0] wa, wb, mask, got;
    bit ok;
    @(negedge clk);
    cfgCpol = pol[0]; cfgCpha = pha[0]; cfgDiv = 8'(div); cfgWordLen = 5'(len);
    cfgInterval = 6'(ivl); invMiso = inv;
    @(negedge clk); @(negedge clk);
    check(sck == cfgCpol, "R3 idle sck", {31'd0, sck}, {31'd0, cfgCpol});
    monEpoch++;
    @(negedge clk);
    wa = 32'hA5C3_1E79 ^ (32'h0101_0101 * 32'(div + len + pol));
    wb = {wa[15:0], ~wa[31:16]} ^ 32'(pha);
    mask = (len == 31) ? 32'hFFFF_FFFF : ((32'd1 << (len + 1)) - 1);
    pushTwo(wa, wb);
    for (int t = 0; t < 3000 && !(doneCnt >= 1 && !busy); t++) @(negedge clk);
    repeat (3) @(negedge clk);
    check(!halfBad, "R1 half period", 32'(halfBad), 32'd0);
    check(bitsArr[0] == len + 1 && bitsArr[1] == len + 1, "R2 bit count",
          32'(bitsArr[0]), 32'(len + 1));
    check(capArr[0] == (wa & mask), "R2 first word on mosi", capArr[0], wa & mask);
    check(capArr[1] == (wb & mask), "R2 second word on mosi", capArr[1], wb & mask);
    check(!phaseBad, "R4 mosi edge placement", 32'(phaseBad), 32'd0);
    check(!gapBad && gapChecks == 1, "R5 inter-word gap", 32'(lowCnt), 32'(ivl * 4 + 10));
    check(doneCnt == 1 && !doneBusy, "R8 single done after busy", 32'(doneCnt), 32'd1);
    popRx(got, ok);
    check(ok && got == ((wa ^ {32{inv}}) & mask), "R4 received word A", got, (wa ^ {32{inv}}) & mask);
    popRx(got, ok);
    check(ok && got == ((wb ^ {32{inv}}) & mask), "R4 received word B", got, (wb ^ {32{inv}}) & mask);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      totalCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", passCnt, totalCnt);
      $finish;
    end
  end

  initial begin
    logic [31:0] got;
    bit ok;
    int divs [3];
    int lens [4];
    divs[0] = 0; divs[1] = 1; divs[2] = 3;
    lens[0] = 0; lens[1] = 7; lens[2] = 12; lens[3] = 31;

    repeat (3) @(negedge clk);
    check(csN == 4'hF, "R6 reset csN", 32'(csN), 32'hF);
    check(!busy && !done, "R8 reset idle", {30'd0, busy, done}, 32'd0);
    check(txEmpty && rxEmpty && !txFull, "R7 reset fifos", {29'd0, txEmpty, rxEmpty, txFull}, 32'd6);
    rst_n = 1'b1;
    @(negedge clk);
    check(sck == 1'b0, "R3 reset sck", {31'd0, sck}, 32'd0);

    // Chip select
    cfgCsSel = 4'b0101; csEnable = 1'b1;
    @(negedge clk);
    check(csN == 4'b1010, "R6 select", 32'(csN), 32'hA);
    csEnable = 1'b0;
    @(negedge clk);
    check(csN == 4'hF, "R6 deselect", 32'(csN), 32'hF);
    cfgCsSel = 4'b0010; csEnable = 1'b1;
    @(negedge clk);

    // Sweep polarity, phase, prescale, length
    for (int pol = 0; pol < 2; pol++)
      for (int pha = 0; pha < 2; pha++)
        for (int di = 0; di < 3; di++)
          for (int li = 0; li < 4; li++)
            runConfig(pol, pha, divs[di], lens[li], di + li, ((li + pha) % 2) == 1);

    // R10 and R7: saturate the receive FIFO with 1-bit words
    @(negedge clk);
    cfgCpol = 1'b0; cfgCpha = 1'b0; cfgDiv = 8'd0; cfgWordLen = 5'd0; cfgInterval = 6'd0;
    invMiso = 1'b0;
    for (int i = 0; i < 32; i++) pushOne(32'(i));
    for (int t = 0; t < 2000 && !rxFull; t++) @(negedge clk);
    check(rxFull, "R10 receive FIFO fills", 32'(rxFull), 32'd1);
    repeat (30) @(negedge clk);
    check(!busy && rxFull, "R10 stalled while rx full", 32'(busy), 32'd0);
    for (int i = 0; i < 32; i++) pushOne(32'(i) ^ 32'd1);
    check(txFull, "R7 transmit FIFO full at 32", 32'(txFull), 32'd1);
    pushOne(32'd1);
    check(!busy, "R10 still stalled", 32'(busy), 32'd0);
    for (int i = 0; i < 64; i++) begin
      logic [31:0] expBit;
      expBit = (i < 32) ? 32'(i & 1) : 32'((i & 1) ^ 1);
      popRx(got, ok);
      check(ok && got == expBit, "R7 ordered drain", got, expBit);
    end
    repeat (200) @(negedge clk);
    check(rxEmpty && txEmpty, "R7 push when full dropped", 32'(rxEmpty), 32'd1);

    // R9: clear in the middle of a long word
    @(negedge clk);
    cfgCpol = 1'b1; cfgCpha = 1'b0; cfgDiv = 8'd3; cfgWordLen = 5'd31; cfgInterval = 6'd2;
    monEpoch++;
    pushTwo(32'h1234_5678, 32'h9ABC_DEF0);
    repeat (40) @(negedge clk);
    check(busy, "R9 busy before clear", 32'(busy), 32'd1);
    fifoClear = 1'b1;
    @(negedge clk);
    fifoClear = 1'b0;
    check(!busy && sck == 1'b1, "R9 idle after clear", {30'd0, busy, sck}, 32'd1);
    check(txEmpty && rxEmpty, "R9 fifos emptied", {30'd0, txEmpty, rxEmpty}, 32'd3);
    check(csN == 4'b1101, "R6 csN kept across clear", 32'(csN), 32'hD);
    repeat (20) @(negedge clk);
    check(doneCnt == 0 && !busy, "R9 no done after clear", 32'(doneCnt), 32'd0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", passCnt, totalCnt);
    $finish;
  end
endmodule